// File: doc/BRIEF.md
# Sticky Reset-Cause Flag Register

This block keeps a record of which reset sources have fired since the last power-up. Each of seven cause inputs delivers a one-cycle pulse when its reset source triggers. The pulse sets a matching flag in the upper byte of a 32-bit status word. A flag stays set until software writes a one to the remove-flags control bit, which clears all the flags together. The flags sit in the power-reset domain, so a system reset leaves them as they were. After start-up, software reads the word to find out why the chip restarted.

The same word also holds a low-speed internal oscillator control. A read/write enable bit drives the oscillator, and a read-only ready bit reports that the oscillator is stable. Both bits are in the system-reset domain. The register is reached through a simple bus with byte-lane enables. The requester holds the request until a one-cycle ready pulse returns. The number of wait states before that pulse is set by a parameter.

Top module: `rstcause_reg`

## Requirements
- R1: After a power reset (applied together with a system reset), the status word reads 0x0E00_0000: only the power-on, pin and brownout flags are set.
- R2: A pulse on `cause_evt[i]` sets status bit 25+i on the next clock edge. The mapping is: index 6 low-power (bit 31), 5 window watchdog (bit 30), 4 independent watchdog (bit 29), 3 software (bit 28), 2 power-on/down (bit 27), 1 pin (bit 26), 0 brownout (bit 25). Any combination of pulses sets exactly the flags it names.
- R3: A set flag stays set when no clear occurs, including across a system reset with `por_n` held high.
- R4: A committed write with lane 3 enabled and data bit 24 at 1 clears all seven flags. A write with bit 24 at 0, or with lane 3 disabled, leaves the flags unchanged.
- R5: When a cause pulse arrives in the same cycle as a clearing write, that flag ends up set and every other flag is cleared.
- R6: Software writes cannot set a flag. Writing ones to bits 31:25 with bit 24 at 0 leaves the flags at 0.
- R7: Bit 24 and the reserved bits 23:2 always read 0, whatever is written to them.
- R8: Bit 0 is the oscillator enable, output on `osc_en`. It is written through lane 0 only and cleared by a system reset.
- R9: Bit 1 (ready) becomes 1 one cycle after the enable is 1 while `osc_stable` is high. It drops one cycle after the enable or `osc_stable` goes low. It is read-only, and a system reset clears it.
- R10: `ready` pulses for one cycle exactly WAIT_STATES cycles after the first cycle of a held request (0 means the same cycle). A write takes effect on the clock edge at the end of the ready cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power reset, active low, for the cause flags |
| sys_rst_n | input | 1 | System reset, active low, for the oscillator bits and the bus counter |
| cause_evt | input | 7 | One-cycle reset-event pulses, index i maps to status bit 25+i |
| req | input | 1 | Access request, held until ready |
| we | input | 1 | 1 for a write, 0 for a read |
| be | input | 4 | Byte-lane enables, lane k covers bits 8k+7:8k |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Status word |
| ready | output | 1 | One-cycle access completion |
| osc_stable | input | 1 | Stability indication from the oscillator |
| osc_en | output | 1 | Oscillator enable |

## Verification
All 128 cause-pulse masks are applied after a clear and read back. This separates a wrong bit position, a missing or crossed flag, and leakage between flags. Clearing writes are tried with bit 24 set, with bit 24 clear, and with lane 3 off, and once with an event landing in the commit cycle. These cases separate a clear that ignores its lane or data bit from one that lets the event lose. Writes with all ones, a system reset on its own, and enable/stable toggles with counted latency separate the two reset domains, the read-only fields and the ready timing. The wait count of every access is measured against the parameter.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int NCAUSE   = 7;
  localparam int FLAG_LSB = 25;
  localparam int RMV_BIT  = 24;
  localparam int EN_BIT   = 0;
  localparam int RDY_BIT  = 1;
  localparam logic [NCAUSE-1:0] POR_FLAGS = 7'b0000111;

  function automatic logic [31:0] pack_status(input logic [NCAUSE-1:0] flags,
                                              input logic en, input logic rdy);
    logic [31:0] w;
    w = '0;
    w[FLAG_LSB +: NCAUSE] = flags;
    w[EN_BIT]  = en;
    w[RDY_BIT] = rdy;
    return w;
  endfunction

  function automatic int cnt_width(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rc_bus_if.sv
module rc_bus_if #(
  parameter int WAIT_STATES = 2
) (
  input  logic clk,
  input  logic sys_rst_n,
  input  logic req,
  input  logic we,
  input  logic lane0,
  input  logic lane3,
  input  logic wbit_rmv,
  input  logic wbit_en,
  output logic ready,
  output logic clr_cmd,
  output logic en_wr,
  output logic en_val
);
  localparam int CW = rc_pkg::cnt_width(WAIT_STATES);
  localparam logic [CW-1:0] LIMIT = CW'(WAIT_STATES);

  logic [CW-1:0] cnt;
  logic          commit;

  assign ready   = req && (cnt == LIMIT);
  assign commit  = ready && we;
  assign clr_cmd = commit && lane3 && wbit_rmv;
  assign en_wr   = commit && lane0;
  assign en_val  = wbit_en;

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n)     cnt <= '0;
    else if (ready)     cnt <= '0;
    else if (req)       cnt <= cnt + 1'b1;
  end

  generate
    if (WAIT_STATES > 0) begin : g_wait_chk
      a_r10_ready_single: assert property (@(posedge clk) disable iff (!sys_rst_n)
        ready |=> !ready);
    end
  endgenerate
endmodule

// File: rtl/rc_cause_flags.sv
module rc_cause_flags #(
  parameter int N = rc_pkg::NCAUSE,
  parameter logic [N-1:0] INIT = rc_pkg::POR_FLAGS
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [N-1:0] evt,
  input  logic         clr,
  output logic [N-1:0] flags
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) flags[i] <= INIT[i];
        else        flags[i] <= evt[i] | (flags[i] & ~clr);
      end
    end
  endgenerate

  a_r2_event_sets: assert property (@(posedge clk) disable iff (!por_n)
    (|evt) |=> ((flags & $past(evt)) == $past(evt)));
  a_r4_clear_all: assert property (@(posedge clk) disable iff (!por_n)
    (clr && (evt == '0)) |=> (flags == '0));
  a_r3_sticky: assert property (@(posedge clk) disable iff (!por_n)
    (!clr) |=> ((flags & $past(flags)) == $past(flags)));
  a_r6_no_sw_set: assert property (@(posedge clk) disable iff (!por_n)
    (evt == '0) |=> ((flags & ~$past(flags)) == '0));
endmodule

// File: rtl/rc_osc_ctrl.sv
module rc_osc_ctrl (
  input  logic clk,
  input  logic sys_rst_n,
  input  logic wr,
  input  logic wval,
  input  logic stable,
  output logic en,
  output logic rdy
);
  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      en  <= 1'b0;
      rdy <= 1'b0;
    end else begin
      if (wr) en <= wval;
      rdy <= en & stable;
    end
  end

  a_r9_rdy_needs_en: assert property (@(posedge clk) disable iff (!sys_rst_n)
    rdy |-> $past(en));
  a_r8_en_hold: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (!wr) |=> $stable(en));
endmodule

// File: rtl/rstcause_reg.sv
module rstcause_reg #(
  parameter int WAIT_STATES = 2
) (
  input  logic                     clk,
  input  logic                     por_n,
  input  logic                     sys_rst_n,
  input  logic [rc_pkg::NCAUSE-1:0] cause_evt,
  input  logic                     req,
  input  logic                     we,
  input  logic [3:0]               be,
  input  logic [31:0]              wdata,
  output logic [31:0]              rdata,
  output logic                     ready,
  input  logic                     osc_stable,
  output logic                     osc_en
);
  import rc_pkg::*;

  logic              clr_cmd, en_wr, en_val, osc_rdy;
  logic [NCAUSE-1:0] flags;
  logic              unused_bits;

  assign unused_bits = ^{wdata[31:25], wdata[23:1], be[2:1]};

  rc_bus_if #(.WAIT_STATES(WAIT_STATES)) u_bus (
    .clk(clk), .sys_rst_n(sys_rst_n), .req(req), .we(we),
    .lane0(be[0]), .lane3(be[3]),
    .wbit_rmv(wdata[RMV_BIT]), .wbit_en(wdata[EN_BIT]),
    .ready(ready), .clr_cmd(clr_cmd), .en_wr(en_wr), .en_val(en_val)
  );

  rc_cause_flags #(.N(NCAUSE), .INIT(POR_FLAGS)) u_flags (
    .clk(clk), .por_n(por_n), .evt(cause_evt), .clr(clr_cmd), .flags(flags)
  );

  rc_osc_ctrl u_osc (
    .clk(clk), .sys_rst_n(sys_rst_n), .wr(en_wr), .wval(en_val),
    .stable(osc_stable), .en(osc_en), .rdy(osc_rdy)
  );

  assign rdata = pack_status(flags, osc_en, osc_rdy);

  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!sys_rst_n)
    rdata[RMV_BIT:2] == '0);
  a_r5_event_wins: assert property (@(posedge clk) disable iff (!por_n)
    (clr_cmd && (cause_evt != '0)) |=> (rdata[31:25] == $past(cause_evt)));
endmodule

// File: tb/rstcause_reg_tb.sv
module rstcause_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WS = 2;

  logic        clk = 0;
  logic        por_n = 0, sys_rst_n = 0;
  logic [6:0]  cause_evt = '0;
  logic        req = 0, we = 0, osc_stable = 0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ready, osc_en;
  int checks = 0, errors = 0;
  int lat;

  always #(CLK_PERIOD/2) clk = ~clk;

  rstcause_reg #(.WAIT_STATES(WS)) u_dut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .cause_evt(cause_evt),
    .req(req), .we(we), .be(be), .wdata(wdata), .rdata(rdata), .ready(ready),
    .osc_stable(osc_stable), .osc_en(osc_en)
  );

  task automatic check(input string req_id, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req_id, act, exp);
    end
  endtask

  function automatic logic [31:0] flag_word(input logic [6:0] m);
    return {m, 25'd0};
  endfunction

  task automatic access(input logic w, input logic [3:0] b, input logic [31:0] d,
                        input logic [6:0] evt_at_commit, output int l);
    @(negedge clk); req = 1; we = w; be = b; wdata = d; l = 0;
    #1;
    while (!ready) begin @(negedge clk); #1; l++; end
    cause_evt = evt_at_commit;
    @(negedge clk); req = 0; we = 0; be = '0; wdata = '0; cause_evt = '0;
    #1;
  endtask

  task automatic pulse(input logic [6:0] m);
    @(negedge clk); cause_evt = m;
    @(negedge clk); cause_evt = '0; #1;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1; sys_rst_n = 1; #1;
    check("R1 reset word", rdata, 32'h0E00_0000);
    check("R8 enable after reset", {31'd0, osc_en}, 32'd0);

    access(1'b0, 4'hF, 32'h0, 7'h0, lat);
    check("R10 read latency", lat, WS);
    check("R3 read leaves flags", rdata, 32'h0E00_0000);

    access(1'b1, 4'h8, 32'h0000_0000, 7'h0, lat);
    check("R4 bit24 zero no clear", rdata, 32'h0E00_0000);
    access(1'b1, 4'h7, 32'h0100_0000, 7'h0, lat);
    check("R4 lane3 off no clear", rdata, 32'h0E00_0000);
    access(1'b1, 4'h8, 32'h0100_0000, 7'h0, lat);
    check("R4 clear all", rdata, 32'h0);
    check("R10 write latency", lat, WS);

    for (int m = 0; m < 128; m++) begin
      access(1'b1, 4'h8, 32'h0100_0000, 7'h0, lat);
      pulse(7'(m));
      check("R2 mask sweep", rdata, flag_word(7'(m)));
      repeat (2) @(negedge clk);
      #1 check("R3 sticky hold", rdata, flag_word(7'(m)));
    end

    for (int i = 0; i < 7; i++) begin
      access(1'b1, 4'h8, 32'h0100_0000, 7'h0, lat);
      pulse(7'h7F);
      access(1'b1, 4'h8, 32'h0100_0000, 7'(1 << i), lat);
      check("R5 event wins over clear", rdata, flag_word(7'(1 << i)));
    end

    access(1'b1, 4'h8, 32'h0100_0000, 7'h0, lat);
    osc_stable = 0;
    access(1'b1, 4'hF, 32'hFEFF_FFFF, 7'h0, lat);
    check("R6 no software set", rdata[31:25], 0);
    check("R7 reserved read zero", rdata, 32'h0000_0001);
    access(1'b1, 4'hF, 32'hFFFF_FFFF, 7'h0, lat);
    check("R7 bit24 reads zero", rdata, 32'h0000_0001);

    pulse(7'h55);
    access(1'b1, 4'h1, 32'h0, 7'h0, lat);
    check("R8 disable via lane0", {31'd0, osc_en}, 32'd0);
    access(1'b1, 4'hE, 32'h0000_0001, 7'h0, lat);
    check("R8 lane0 off ignored", {31'd0, osc_en}, 32'd0);

    osc_stable = 1;
    access(1'b1, 4'h1, 32'h1, 7'h0, lat);
    check("R9 ready not yet", rdata[1:0], 2'b01);
    @(negedge clk); #1;
    check("R9 ready rises", rdata[1:0], 2'b11);
    access(1'b1, 4'h1, 32'h3, 7'h0, lat);
    check("R9 ready read-only", rdata, flag_word(7'h55) | 32'h3);
    @(negedge clk); osc_stable = 0;
    @(negedge clk); #1;
    check("R9 ready drops with stable", rdata[1:0], 2'b01);
    osc_stable = 1;
    @(negedge clk); #1;
    check("R9 ready back", rdata[1:0], 2'b11);
    access(1'b1, 4'h1, 32'h0, 7'h0, lat);
    check("R9 ready one cycle after disable", rdata[1:0], 2'b10);
    @(negedge clk); #1;
    check("R9 ready off", rdata[1:0], 2'b00);

    access(1'b1, 4'h1, 32'h1, 7'h0, lat);
    @(negedge clk); #1;
    @(negedge clk); sys_rst_n = 0;
    @(negedge clk); sys_rst_n = 1; #1;
    check("R3 flags survive system reset", rdata, flag_word(7'h55));
    check("R8 R9 osc cleared by system reset", {31'd0, osc_en}, 32'd0);

    @(negedge clk); por_n = 0; sys_rst_n = 0;
    @(negedge clk); por_n = 1; sys_rst_n = 1; #1;
    check("R1 power reset word", rdata, 32'h0E00_0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule